// File: doc/BRIEF.md
# GCR 6-and-2 Sector Data Decoder

This block sits on the byte stream from a floppy read channel once the caller has matched a sector header. A `start` pulse arms it. It then hunts for the three-byte data mark and reads the single disk byte that follows as the sector number. Next it decodes the payload of tag bytes and data bytes. Each payload group is four disk bytes: one disk byte holds the upper bit pairs of three output bytes, and three more disk bytes hold their lower six bits.

While it decodes, the block runs three 8-bit running sums that share one carry, and it uses them to unscramble every byte. At the end it compares the sums with the checksum group on the disk and checks the two-byte trailer. Decoded bytes leave on a valid/last stream. The block ends each attempt with a one-cycle `done` pulse and a status code, and then goes idle.

The disk side has no back-pressure. A byte is taken in every cycle that `disk_valid` is high. Every output is registered, so a disk byte's effect shows on the outputs in the cycle after it is taken.

Top module: `gcr_sector_decoder`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `sect_valid`, `out_valid`, `out_last` and `done` are low and `status` is 0.
- R2: After `start`, the data mark is the byte sequence 0xD5, 0xAA, 0xAD. A byte that breaks a partial match restarts the hunt, and a 0xD5 that breaks the match counts as the first byte of a new attempt.
- R3: If the mark is not complete within SEARCH_LIMIT (default 50) disk bytes after `start`, `done` pulses with status 1 on the SEARCH_LIMIT-th byte. A mark whose last byte is exactly the SEARCH_LIMIT-th byte is accepted.
- R4: The disk byte right after the mark is decoded as a nibble. Its value appears on `sect_num` together with a one-cycle `sect_valid`.
- R5: A legal disk code has bit 7 set, has at least one pair of adjacent ones within bits 6..0, and has at most one pair of adjacent zeros. There are 64 legal codes, and the nibble value of a code is its rank in ascending order. An illegal code in the sector-number, payload or checksum position ends the attempt with status 2.
- R6: Payload groups are four disk bytes. In the first disk byte, nibble bits 5:4 are the top bits of byte A, bits 3:2 those of B, and bits 1:0 those of C. The next three disk bytes give the low six bits of A, B and C. Bytes leave in order A, B, C.
- R7: At the start of the payload, sums S1, S2, S3 and carry K are zero. For A: K takes bit 7 of S3, S3 rotates left by one, A is the raw byte XOR S3, and S1 = S1 + A + K with K taking the carry out. B is the raw byte XOR S1, then S2 = S2 + B + K. C is the raw byte XOR S2, then S3 = S3 + C + K.
- R8: The payload is TAG_BYTES + DATA_BYTES bytes (default 524). The last group carries only A and B. `out_last` is high only with the final payload byte.
- R9: After the payload comes a group of four disk bytes in the same six-and-two form. Its three bytes must equal S1, S2 and S3. A mismatch ends the attempt with status 3.
- R10: The trailer 0xDE, 0xAA must follow. On success `done` pulses with status 0. A wrong trailer byte gives status 4.
- R11: After `done`, disk bytes produce no output and no further `done` until the next `start`.
- R12: Cycles with `disk_valid` low have no effect on the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms a new hunt; takes priority over any disk byte in the same cycle |
| disk_valid | input | 1 | `disk_byte` carries a byte this cycle |
| disk_byte | input | 8 | Raw disk byte |
| busy | output | 1 | An attempt is in progress |
| sect_valid | output | 1 | `sect_num` is new this cycle |
| sect_num | output | 6 | Decoded sector number |
| out_valid | output | 1 | `out_byte` carries a payload byte |
| out_byte | output | 8 | Unscrambled payload byte |
| out_last | output | 1 | Final payload byte |
| done | output | 1 | One-cycle end-of-attempt pulse |
| status | output | 3 | 0 ok, 1 no mark, 2 bad code, 3 checksum mismatch, 4 bad trailer |

## Verification
Two events can fall on the same disk byte: completing the data mark and reaching the search limit. The mark must win. The bench tests this by placing exactly 47 filler bytes ahead of a good sector, so the final 0xAD is the 50th byte and the sector must then decode cleanly. It repeats the test with 48 filler bytes, where the 50th byte is 0xAA, and expects status 1 on that byte and silence afterwards. An exhaustive sweep of all 256 values in the sector-number position checks the code map against a rank that the bench computes from the legality rule.

// File: rtl/gcr_dec_pkg.sv
package gcr_dec_pkg;

   typedef enum logic [2:0] {
      ST_OK         = 3'd0,
      ST_NO_MARK    = 3'd1,
      ST_BAD_NIBBLE = 3'd2,
      ST_BAD_SUM    = 3'd3,
      ST_BAD_TAIL   = 3'd4
   } gcr_status_e;

   // Position inside a four-byte six-and-two group.
   typedef enum logic [1:0] {
      LANE_FRAG = 2'd0,
      LANE_A    = 2'd1,
      LANE_B    = 2'd2,
      LANE_C    = 2'd3
   } gcr_lane_e;

   typedef struct packed {
      logic [7:0] s1;
      logic [7:0] s2;
      logic [7:0] s3;
      logic       k;
   } gcr_sums_t;

   localparam logic [7:0] MARK_B0 = 8'hD5;
   localparam logic [7:0] MARK_B1 = 8'hAA;
   localparam logic [7:0] MARK_B2 = 8'hAD;
   localparam logic [7:0] TAIL_B0 = 8'hDE;
   localparam logic [7:0] TAIL_B1 = 8'hAA;

   // Legal disk code: top bit set, some adjacent ones below it,
   // no more than one adjacent zero pair.
   function automatic logic is_disk_code(input logic [7:0] b);
      logic ones_pair;
      int   zero_pairs;
      ones_pair  = 1'b0;
      zero_pairs = 0;
      for (int i = 0; i < 6; i++)
         if (b[i] && b[i+1]) ones_pair = 1'b1;
      for (int i = 0; i < 7; i++)
         if (!b[i] && !b[i+1]) zero_pairs++;
      return b[7] && ones_pair && (zero_pairs <= 1);
   endfunction

   // {legal, rank} for every byte value.
   function automatic logic [255:0][6:0] build_code_map();
      logic [255:0][6:0] m;
      int r;
      r = 0;
      for (int v = 0; v < 256; v++) begin
         if (is_disk_code(8'(v))) begin
            m[v] = {1'b1, 6'(r)};
            r++;
         end else begin
            m[v] = '0;
         end
      end
      return m;
   endfunction

endpackage

// File: rtl/gcr_nibble_map.sv
module gcr_nibble_map
   import gcr_dec_pkg::*;
#(
   parameter bit USE_ROM = 1'b1
) (
   input  logic [7:0] code_i,
   output logic       ok_o,
   output logic [5:0] val_o
);

   generate
      if (USE_ROM) begin : g_rom
         localparam logic [255:0][6:0] CODE_MAP = build_code_map();
         assign {ok_o, val_o} = CODE_MAP[code_i];
      end else begin : g_rank
         logic [5:0] below;
         always_comb begin
            below = '0;
            for (int v = 0; v < 256; v++)
               if ((8'(v) < code_i) && is_disk_code(8'(v)))
                  below = below + 6'd1;
         end
         assign ok_o  = is_disk_code(code_i);
         assign val_o = below;
      end
   endgenerate

endmodule

// File: rtl/gcr_mark_finder.sv
module gcr_mark_finder
   import gcr_dec_pkg::*;
#(
   parameter int SEARCH_LIMIT = 50
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm_i,
   input  logic       en_i,
   input  logic [7:0] byte_i,
   output logic       found_o,
   output logic       expired_o
);

   localparam int CW = $clog2(SEARCH_LIMIT + 1);

   initial assert (SEARCH_LIMIT >= 3)
      else $error("search window shorter than the mark");

   logic [1:0]    stage;
   logic [CW-1:0] seen;

   assign found_o   = en_i && (stage == 2'd2) && (byte_i == MARK_B2);
   assign expired_o = en_i && !found_o && (seen == CW'(SEARCH_LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage <= '0;
         seen  <= '0;
      end else if (arm_i) begin
         stage <= '0;
         seen  <= '0;
      end else if (en_i) begin
         seen <= seen + CW'(1);
         if (found_o)
            stage <= '0;
         else if (byte_i == MARK_B0)
            stage <= 2'd1;
         else if ((stage == 2'd1) && (byte_i == MARK_B1))
            stage <= 2'd2;
         else
            stage <= '0;
      end
   end

   AST_HUNT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |-> (seen < CW'(SEARCH_LIMIT))); // R3

endmodule

// File: rtl/gcr_sum_chain.sv
module gcr_sum_chain
   import gcr_dec_pkg::*;
(
   input  gcr_lane_e  lane_i,
   input  logic [7:0] raw_i,
   input  gcr_sums_t  sums_i,
   output logic [7:0] plain_o,
   output gcr_sums_t  sums_o
);

   logic [8:0] acc;
   logic [7:0] rot;

   always_comb begin
      sums_o  = sums_i;
      plain_o = raw_i;
      acc     = '0;
      rot     = {sums_i.s3[6:0], sums_i.s3[7]};
      case (lane_i)
         LANE_A: begin
            plain_o   = raw_i ^ rot;
            acc       = {1'b0, sums_i.s1} + {1'b0, plain_o} + 9'(sums_i.s3[7]);
            sums_o.s3 = rot;
            sums_o.s1 = acc[7:0];
            sums_o.k  = acc[8];
         end
         LANE_B: begin
            plain_o   = raw_i ^ sums_i.s1;
            acc       = {1'b0, sums_i.s2} + {1'b0, plain_o} + 9'(sums_i.k);
            sums_o.s2 = acc[7:0];
            sums_o.k  = acc[8];
         end
         LANE_C: begin
            plain_o   = raw_i ^ sums_i.s2;
            acc       = {1'b0, sums_i.s3} + {1'b0, plain_o} + 9'(sums_i.k);
            sums_o.s3 = acc[7:0];
            sums_o.k  = acc[8];
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/gcr_sector_decoder.sv
module gcr_sector_decoder
   import gcr_dec_pkg::*;
#(
   parameter int TAG_BYTES    = 12,
   parameter int DATA_BYTES   = 512,
   parameter int SEARCH_LIMIT = 50,
   parameter bit ROM_MAP      = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       disk_valid,
   input  logic [7:0] disk_byte,
   output logic       busy,
   output logic       sect_valid,
   output logic [5:0] sect_num,
   output logic       out_valid,
   output logic [7:0] out_byte,
   output logic       out_last,
   output logic       done,
   output logic [2:0] status
);

   localparam int PAYLOAD = TAG_BYTES + DATA_BYTES;
   localparam int CNT_W   = $clog2(PAYLOAD);

   initial assert (PAYLOAD % 3 == 2 && PAYLOAD >= 2)
      else $error("payload must end in a two-byte group");

   typedef enum logic [2:0] {
      S_IDLE, S_HUNT, S_SECT, S_BODY, S_SUM, S_TAIL
   } dec_state_e;

   dec_state_e       state;
   gcr_lane_e        phase;
   logic [5:0]       frag;
   gcr_sums_t        sums, sums_nx;
   logic [CNT_W-1:0] pay_cnt;
   logic             tail_second;

   logic       nib_ok;
   logic [5:0] nib;
   logic       mark_found, mark_expired;
   logic [1:0] top_pair;
   logic [7:0] raw;
   logic [7:0] plain;
   logic [7:0] sum_expect;
   gcr_lane_e  chain_lane;
   logic       is_last;

   gcr_nibble_map #(.USE_ROM(ROM_MAP)) i_map (
      .code_i (disk_byte),
      .ok_o   (nib_ok),
      .val_o  (nib)
   );

   gcr_mark_finder #(.SEARCH_LIMIT(SEARCH_LIMIT)) i_finder (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (start),
      .en_i      (disk_valid && !start && (state == S_HUNT)),
      .byte_i    (disk_byte),
      .found_o   (mark_found),
      .expired_o (mark_expired)
   );

   always_comb begin
      case (phase)
         LANE_A:  begin top_pair = frag[5:4]; sum_expect = sums.s1; end
         LANE_B:  begin top_pair = frag[3:2]; sum_expect = sums.s2; end
         LANE_C:  begin top_pair = frag[1:0]; sum_expect = sums.s3; end
         default: begin top_pair = 2'b00;     sum_expect = 8'h00;   end
      endcase
   end

   assign raw        = {top_pair, nib};
   assign chain_lane = (state == S_BODY) ? phase : LANE_FRAG;
   assign is_last    = (pay_cnt == CNT_W'(PAYLOAD - 1));

   gcr_sum_chain i_chain (
      .lane_i  (chain_lane),
      .raw_i   (raw),
      .sums_i  (sums),
      .plain_o (plain),
      .sums_o  (sums_nx)
   );

   assign busy = (state != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         phase       <= LANE_FRAG;
         frag        <= '0;
         sums        <= '0;
         pay_cnt     <= '0;
         tail_second <= 1'b0;
         sect_valid  <= 1'b0;
         sect_num    <= '0;
         out_valid   <= 1'b0;
         out_byte    <= '0;
         out_last    <= 1'b0;
         done        <= 1'b0;
         status      <= ST_OK;
      end else begin
         sect_valid <= 1'b0;
         out_valid  <= 1'b0;
         out_last   <= 1'b0;
         done       <= 1'b0;
         if (start) begin
            state <= S_HUNT;
         end else if (disk_valid) begin
            case (state)
               S_HUNT: begin
                  if (mark_found) begin
                     state <= S_SECT;
                  end else if (mark_expired) begin
                     done   <= 1'b1;
                     status <= ST_NO_MARK;
                     state  <= S_IDLE;
                  end
               end
               S_SECT: begin
                  if (!nib_ok) begin
                     done   <= 1'b1;
                     status <= ST_BAD_NIBBLE;
                     state  <= S_IDLE;
                  end else begin
                     sect_valid <= 1'b1;
                     sect_num   <= nib;
                     sums       <= '0;
                     phase      <= LANE_FRAG;
                     pay_cnt    <= '0;
                     state      <= S_BODY;
                  end
               end
               S_BODY: begin
                  if (!nib_ok) begin
                     done   <= 1'b1;
                     status <= ST_BAD_NIBBLE;
                     state  <= S_IDLE;
                  end else if (phase == LANE_FRAG) begin
                     frag  <= nib;
                     phase <= LANE_A;
                  end else begin
                     out_valid <= 1'b1;
                     out_byte  <= plain;
                     out_last  <= is_last;
                     sums      <= sums_nx;
                     pay_cnt   <= pay_cnt + CNT_W'(1);
                     if (is_last) begin
                        phase <= LANE_FRAG;
                        state <= S_SUM;
                     end else if (phase == LANE_C) begin
                        phase <= LANE_FRAG;
                     end else begin
                        phase <= gcr_lane_e'(phase + 2'd1);
                     end
                  end
               end
               S_SUM: begin
                  if (!nib_ok) begin
                     done   <= 1'b1;
                     status <= ST_BAD_NIBBLE;
                     state  <= S_IDLE;
                  end else if (phase == LANE_FRAG) begin
                     frag  <= nib;
                     phase <= LANE_A;
                  end else if (raw != sum_expect) begin
                     done   <= 1'b1;
                     status <= ST_BAD_SUM;
                     state  <= S_IDLE;
                  end else if (phase == LANE_C) begin
                     tail_second <= 1'b0;
                     state       <= S_TAIL;
                  end else begin
                     phase <= gcr_lane_e'(phase + 2'd1);
                  end
               end
               S_TAIL: begin
                  if (!tail_second && disk_byte == TAIL_B0) begin
                     tail_second <= 1'b1;
                  end else begin
                     done   <= 1'b1;
                     status <= (tail_second && disk_byte == TAIL_B1) ? ST_OK : ST_BAD_TAIL;
                     state  <= S_IDLE;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // Checker-side count of emitted payload bytes per attempt.
   logic [CNT_W:0] emitted;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         emitted <= '0;
      else if (start)     emitted <= '0;
      else if (out_valid) emitted <= emitted + (CNT_W+1)'(1);
   end

   AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid); // R8
   AST_OK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == ST_OK) |-> (emitted == (CNT_W+1)'(PAYLOAD))); // R8
   AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(disk_valid)); // R12
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid || done) |-> $past(busy)); // R11
   AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status <= 3'd4)); // R10

endmodule

// File: tb/test_gcr_sector_decoder.sv
module test_gcr_sector_decoder;

   localparam int CLK_PERIOD = 10;
   localparam int PAY        = 524;
   localparam int LIMIT      = 50;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       disk_valid = 1'b0;
   logic [7:0] disk_byte = 8'h00;
   logic       busy, sect_valid, out_valid, out_last, done;
   logic [5:0] sect_num;
   logic [7:0] out_byte;
   logic [2:0] status;

   gcr_sector_decoder i_gcr_sector_decoder (
      .clk(clk), .rst_n(rst_n), .start(start), .disk_valid(disk_valid),
      .disk_byte(disk_byte), .busy(busy), .sect_valid(sect_valid),
      .sect_num(sect_num), .out_valid(out_valid), .out_byte(out_byte),
      .out_last(out_last), .done(done), .status(status)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   logic [7:0] enc_tab [64];
   logic [7:0] plain [PAY];
   logic [7:0] strm [1024];
   int slen;
   logic [7:0] s1, s2, s3;

   int got_n, bad_bytes, last_cnt, last_at, done_cnt, done_at, pushed, sect_cnt;
   logic [2:0] done_st;
   logic [5:0] sect_val;

   task automatic check(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit legal_code(input logic [7:0] b);
      int ones, zeros;
      ones = 0; zeros = 0;
      for (int i = 0; i < 6; i++) if (b[i] & b[i+1]) ones++;
      for (int i = 0; i < 7; i++) if (!b[i] & !b[i+1]) zeros++;
      return b[7] && ones > 0 && zeros < 2;
   endfunction

   task automatic clear_rec();
      got_n = 0; bad_bytes = 0; last_cnt = 0; last_at = -1; done_cnt = 0;
      done_at = -1; pushed = 0; sect_cnt = 0; done_st = 3'd7; sect_val = '0;
   endtask

   task automatic sample();
      if (out_valid) begin
         if (got_n < PAY && out_byte !== plain[got_n]) bad_bytes++;
         if (out_last) begin last_cnt++; last_at = got_n; end
         got_n++;
      end
      if (done) begin done_cnt++; done_at = pushed; done_st = status; end
      if (sect_valid) begin sect_cnt++; sect_val = sect_num; end
   endtask

   task automatic tick(input bit v, input logic [7:0] b);
      disk_valid = v; disk_byte = b;
      @(negedge clk);
      disk_valid = 1'b0;
      if (v) pushed++;
      sample();
   endtask

   task automatic do_start();
      clear_rec();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      sample();
   endtask

   task automatic emit(input logic [7:0] b);
      strm[slen] = b; slen++;
   endtask

   // Encoder model built from the requirements: scramble plain bytes forward.
   task automatic build(input int sect);
      logic [8:0] t;
      logic k;
      logic [7:0] ra, rb, rc;
      s1 = 0; s2 = 0; s3 = 0; k = 0; slen = 0;
      emit(8'hD5); emit(8'hAA); emit(8'hAD); emit(enc_tab[sect]);
      for (int idx = 0; idx < PAY; idx += 3) begin
         k  = s3[7];
         s3 = {s3[6:0], s3[7]};
         ra = plain[idx] ^ s3;
         t  = s1 + plain[idx] + k; s1 = t[7:0]; k = t[8];
         rb = plain[idx+1] ^ s1;
         t  = s2 + plain[idx+1] + k; s2 = t[7:0]; k = t[8];
         rc = 8'h00;
         if (idx + 2 < PAY) begin
            rc = plain[idx+2] ^ s2;
            t  = s3 + plain[idx+2] + k; s3 = t[7:0]; k = t[8];
         end
         emit(enc_tab[{ra[7:6], rb[7:6], rc[7:6]}]);
         emit(enc_tab[ra[5:0]]);
         emit(enc_tab[rb[5:0]]);
         if (idx + 2 < PAY) emit(enc_tab[rc[5:0]]);
      end
      emit(enc_tab[{s1[7:6], s2[7:6], s3[7:6]}]);
      emit(enc_tab[s1[5:0]]); emit(enc_tab[s2[5:0]]); emit(enc_tab[s3[5:0]]);
      emit(8'hDE); emit(8'hAA);
   endtask

   task automatic run_stream(input bit gaps);
      for (int i = 0; i < slen; i++) begin
         if (gaps && (i % 5 == 2)) tick(1'b0, 8'h00);
         tick(1'b1, strm[i]);
      end
      repeat (3) tick(1'b0, 8'h00);
   endtask

   task automatic fill(input int p);
      for (int i = 0; i < PAY; i++)
         case (p)
            0: plain[i] = 8'((i * 37 + 11) & 255);
            1: plain[i] = 8'hFF;
            default: plain[i] = 8'h00;
         endcase
   endtask

   initial begin
      int r;
      repeat (3) @(negedge clk);
      check(!busy && !sect_valid && !out_valid && !out_last && !done && status == 0,
            "R1 reset state", {busy, out_valid, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !out_valid && !done && status == 0, "R1 after release", {busy, done}, 0);

      r = 0;
      for (int v = 128; v < 256; v++)
         if (legal_code(8'(v))) begin enc_tab[r] = 8'(v); r++; end
      check(r == 64, "R5 legal code count", r, 64);

      // Good sectors, three patterns; pattern 1 with input gaps (R12).
      for (int p = 0; p < 3; p++) begin
         fill(p);
         build(p * 20 + 5);
         do_start();
         check(busy, "R2 busy after start", busy, 1);
         run_stream(p == 1);
         check(sect_cnt == 1 && sect_val == 6'(p * 20 + 5), "R4 sector number", sect_val, p * 20 + 5);
         check(got_n == PAY, "R6 payload byte count", got_n, PAY);
         check(bad_bytes == 0, p == 1 ? "R12 R7 payload with gaps" : "R7 payload values", bad_bytes, 0);
         check(last_cnt == 1 && last_at == PAY - 1, "R8 last flag", last_at, PAY - 1);
         check(done_cnt == 1 && done_st == 0, "R10 good sector status", done_st, 0);
         check(!busy, "R11 idle after done", busy, 0);
      end

      // Partial mark restart (R2).
      fill(0); build(9);
      do_start();
      tick(1'b1, 8'hD5); tick(1'b1, 8'hAA); tick(1'b1, 8'hD5);
      run_stream(1'b0);
      check(done_cnt == 1 && done_st == 0 && sect_val == 6'd9, "R2 mark after partial match", done_st, 0);

      // Search limit (R3).
      do_start();
      for (int i = 0; i < LIMIT - 1; i++) tick(1'b1, 8'h96);
      check(done_cnt == 0, "R3 no timeout before limit", done_cnt, 0);
      tick(1'b1, 8'h96);
      check(done_cnt == 1 && done_st == 1 && done_at == LIMIT, "R3 timeout on limit byte", done_at, LIMIT);

      // Mark completing on the limit byte is accepted (R3).
      do_start();
      for (int i = 0; i < LIMIT - 3; i++) tick(1'b1, 8'h96);
      run_stream(1'b0);
      check(done_cnt == 1 && done_st == 0 && got_n == PAY, "R3 mark on limit byte", done_st, 0);

      // One byte later: timeout, then silence (R3, R11).
      do_start();
      for (int i = 0; i < LIMIT - 2; i++) tick(1'b1, 8'h96);
      run_stream(1'b0);
      check(done_cnt == 1 && done_st == 1 && done_at == LIMIT, "R3 mark past limit", done_at, LIMIT);
      check(got_n == 0 && sect_cnt == 0, "R11 ignored after error", got_n, 0);

      // Illegal code in payload (R5).
      fill(0); build(3);
      strm[44] = 8'h80;
      do_start(); run_stream(1'b0);
      check(done_cnt == 1 && done_st == 2, "R5 bad payload code", done_st, 2);
      check(got_n == 30, "R5 bytes before bad code", got_n, 30);

      // Checksum mismatch (R9).
      fill(2); build(7);
      strm[slen - 4] = enc_tab[s2[5:0] ^ 6'h01];
      do_start(); run_stream(1'b0);
      check(done_cnt == 1 && done_st == 3 && got_n == PAY, "R9 checksum mismatch", done_st, 3);

      // Bad trailer (R10).
      fill(1); build(1);
      strm[slen - 1] = 8'h96;
      do_start(); run_stream(1'b0);
      check(done_cnt == 1 && done_st == 4, "R10 bad trailer", done_st, 4);

      // Exhaustive sweep of the sector-number position (R4, R5).
      r = 0;
      for (int v = 0; v < 256; v++) begin
         do_start();
         tick(1'b1, 8'hD5); tick(1'b1, 8'hAA); tick(1'b1, 8'hAD); tick(1'b1, 8'(v));
         if (legal_code(8'(v))) begin
            check(sect_cnt == 1 && done_cnt == 0 && sect_val == 6'(r), "R4 R5 code rank", sect_val, r);
            r++;
         end else begin
            check(done_cnt == 1 && done_st == 2 && sect_cnt == 0, "R5 illegal sector code", done_st, 2);
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule